// File: doc/BRIEF.md
# Triggered Sample-Hold Channel Controller

This block sequences two sample-and-hold input channels from an external trigger. A capture on a channel runs a fixed sequence: a discharge phase that empties the input node and the hold capacitor, a sample phase, and a hold phase in which the channel waits for the shared converter. The converter is reached through a request/acknowledge handshake. The controller writes the value that comes back into a buffer slot reserved for that channel and then raises that channel's data-available interrupt flag.

A mode bit ties both channels to one trigger, so that both sample at the same instant. With the bit clear, each channel has its own trigger line. Software sets the channel enables, the mode and the two phase lengths over a small register bus. Software also clears the flags by writing ones to them. The block drives the discharge and sample switch controls. It does not model the analog switches.

Top module: `shc_top`

## Requirements
- R1: After reset, every output is low and every register reads as zero.
- R2: Register 0 holds the enable of channel 0 in bit 0 and the enable of channel 1 in bit 1. A trigger on a disabled channel starts no discharge, causes no buffer write and leaves its flag unchanged.
- R3: Each trigger line passes through two synchronizing flip-flops. A rising edge starts a capture, and `dis_o` rises on the third clock edge after the line goes high. Holding the line high starts no further capture.
- R4: Discharge lasts D+1 cycles, where D is register 1 bits [7:0]. Sample follows immediately and lasts S+1 cycles, where S is register 1 bits [15:8].
- R5: With register 0 bit 2 set, both enabled channels start from a rising edge on `trig_in[0]` in the same cycle, and `trig_in[1]` is ignored. With the bit clear, channel i starts only from `trig_in[i]`.
- R6: Only one conversion is outstanding at a time. `conv_req` and `conv_chan` stay unchanged until `conv_ack`. When both channels are waiting, channel 0 is served first.
- R7: One cycle after `conv_ack`, `buf_we` pulses with `buf_wdata` equal to `conv_data` at the acknowledge. `buf_addr` is 22 for channel 0 and 23 for channel 1.
- R8: A channel's flag rises in the same cycle as its buffer write. The flag is visible on `irq_o[i]` and in register 2 bit i.
- R9: A flag clears only when a 1 is written to its bit of register 2. Writing 0, or running a new capture, leaves it set.
- R10: A rising trigger edge that arrives while a channel is still busy with a capture is ignored for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 timing, 2 flags) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| trig_in | input | 2 | Asynchronous trigger lines |
| dis_o | output | 2 | Discharge switch control per channel |
| samp_o | output | 2 | Sample switch control per channel |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 1 | Channel of the requested conversion |
| conv_ack | input | 1 | Conversion done, data valid |
| conv_data | input | 16 | Converted value |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 5 | Buffer slot address |
| buf_wdata | output | 16 | Buffer write data |
| irq_o | output | 2 | Per-channel data-available flags |

## Verification
The hardest situation to reach is both channels sitting in hold at the same moment. That is the only case where the arbitration order shows, and it needs equal phase lengths plus triggers that land in the same synchronizer cycle. The randomized loop reaches it often, either through the dual mode or by pulsing both trigger lines together in separate mode. The converter model adds random acknowledge delays, so the second channel waits for different lengths of time. Directed cases retrigger during a long discharge and hold a trigger high, to show that no second capture begins.

// File: rtl/shc_pkg.sv
package shc_pkg;
    localparam int NCH = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DISCH  = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_WAIT   = 2'd3
    } phase_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_TIME = 2'd1;
    localparam logic [1:0] A_FLAG = 2'd2;
endpackage

// File: rtl/shc_trig_edge.sv
module shc_trig_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] trig_in,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = trig_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/shc_chan_seq.sv
module shc_chan_seq
    import shc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] dis_len_i,
    input  logic [CNT_W-1:0] samp_len_i,
    input  logic             done_i,
    output logic             dis_o,
    output logic             samp_o,
    output logic             want_o,
    output logic             busy_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_DISCH;
                    st_d.cnt = '0;
                end
            end
            PH_DISCH: begin
                if (st_q.cnt == dis_len_i) begin
                    st_d.ph  = PH_SAMPLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_SAMPLE: begin
                if (st_q.cnt == samp_len_i) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (done_i) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dis_o  = (st_q.ph == PH_DISCH);
    assign samp_o = (st_q.ph == PH_SAMPLE);
    assign want_o = (st_q.ph == PH_WAIT);
    assign busy_o = (st_q.ph != PH_IDLE);
endmodule

// File: rtl/shc_conv_arb.sv
module shc_conv_arb
    import shc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int SLOT0  = 22,
    parameter int SLOT1  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    want_i,
    input  logic              conv_ack,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_req,
    output logic              conv_chan,
    output logic [NCH-1:0]    done_o,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata
);
    localparam logic [ADDR_W-1:0] SLOT0_A = ADDR_W'(SLOT0);
    localparam logic [ADDR_W-1:0] SLOT1_A = ADDR_W'(SLOT1);

    typedef struct packed {
        logic              req;
        logic              chan;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic finish;

    assign finish = st_q.req & conv_ack;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (st_q.req) begin
            if (conv_ack) begin
                st_d.req  = 1'b0;
                st_d.we   = 1'b1;
                st_d.addr = st_q.chan ? SLOT1_A : SLOT0_A;
                st_d.data = conv_data;
            end
        end else if (want_i[0]) begin
            st_d.req  = 1'b1;
            st_d.chan = 1'b0;
        end else if (want_i[1]) begin
            st_d.req  = 1'b1;
            st_d.chan = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_done
        assign done_o[i] = finish & (st_q.chan == 1'(i));
    end

    assign conv_req  = st_q.req;
    assign conv_chan = st_q.chan;
    assign buf_we    = st_q.we;
    assign buf_addr  = st_q.addr;
    assign buf_wdata = st_q.data;
endmodule

// File: rtl/shc_top.sv
module shc_top
    import shc_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int SLOT0  = 22,
    parameter int SLOT1  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [1:0]        trig_in,
    output logic [1:0]        dis_o,
    output logic [1:0]        samp_o,
    output logic              conv_req,
    output logic              conv_chan,
    input  logic              conv_ack,
    input  logic [DATA_W-1:0] conv_data,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic [1:0]        irq_o
);
    localparam int CNT_W = REG_W / 2;

    typedef struct packed {
        logic [NCH-1:0]   en;
        logic             dual;
        logic [CNT_W-1:0] dis_len;
        logic [CNT_W-1:0] samp_len;
        logic [NCH-1:0]   flag;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [NCH-1:0] rise, trig_sel, start, busy, want, done;
    logic           unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:3];

    shc_trig_edge #(.W(NCH)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .rise_o  (rise)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign trig_sel[i] = rg_q.dual ? rise[0] : rise[i];
        assign start[i]    = trig_sel[i] & rg_q.en[i] & ~busy[i];

        shc_chan_seq #(.CNT_W(CNT_W)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (start[i]),
            .dis_len_i  (rg_q.dis_len),
            .samp_len_i (rg_q.samp_len),
            .done_i     (done[i]),
            .dis_o      (dis_o[i]),
            .samp_o     (samp_o[i]),
            .want_o     (want[i]),
            .busy_o     (busy[i])
        );
    end

    shc_conv_arb #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SLOT0  (SLOT0),
        .SLOT1  (SLOT1)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_i    (want),
        .conv_ack  (conv_ack),
        .conv_data (conv_data),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .done_o    (done),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

    always_comb begin
        logic [NCH-1:0] clr;
        logic [NCH-1:0] set;
        rg_d = rg_q;
        clr  = '0;
        set  = done;
        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    rg_d.en   = reg_wdata[1:0];
                    rg_d.dual = reg_wdata[2];
                end
                A_TIME: begin
                    rg_d.dis_len  = reg_wdata[CNT_W-1:0];
                    rg_d.samp_len = reg_wdata[REG_W-1:CNT_W];
                end
                A_FLAG:  clr = reg_wdata[1:0];
                default: ;
            endcase
        end
        rg_d.flag = (rg_q.flag & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[2:0] = {rg_q.dual, rg_q.en};
            A_TIME:  reg_rdata = {rg_q.samp_len, rg_q.dis_len};
            A_FLAG:  reg_rdata[1:0] = rg_q.flag;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o = rg_q.flag;
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 5,
    parameter int SLOT0  = 22,
    parameter int SLOT1  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [1:0]        dis_o,
    input logic [1:0]        samp_o,
    input logic              conv_req,
    input logic              conv_chan,
    input logic              conv_ack,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [1:0]        irq_o
);
    // R4
    samp0_after_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_o[0]) |-> $past(dis_o[0]));
    // R4
    samp1_after_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_o[1]) |-> $past(dis_o[1]));
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_ack) |=> (conv_req && $stable(conv_chan)));
    // R7
    write_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(conv_req && conv_ack));
    // R7
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr == ($past(conv_chan) ? ADDR_W'(SLOT1) : ADDR_W'(SLOT0))));
    // R8
    flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[0]) |-> (buf_we && buf_addr == ADDR_W'(SLOT0)));
    // R8
    flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[1]) |-> (buf_we && buf_addr == ADDR_W'(SLOT1)));
    // R9
    flag0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o[0]) |-> $past(reg_wr && reg_addr == 2'd2 && reg_wdata[0]));
    // R9
    flag1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o[1]) |-> $past(reg_wr && reg_addr == 2'd2 && reg_wdata[1]));
endmodule

bind shc_top shc_checker #(
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W),
    .SLOT0  (SLOT0),
    .SLOT1  (SLOT1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dis_o     (dis_o),
    .samp_o    (samp_o),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .conv_ack  (conv_ack),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .irq_o     (irq_o)
);

// File: tb/shc_top_test.sv
module shc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  trig_in = '0;
    logic [1:0]  dis_o, samp_o, irq_o;
    logic        conv_req, conv_chan, buf_we;
    logic        conv_ack = 1'b0;
    logic [15:0] conv_data = '0;
    logic [4:0]  buf_addr;
    logic [15:0] buf_wdata;

    int checks = 0, failures = 0, cycles = 0;
    int wr_cnt[2];
    int dis_run[2], samp_run[2];
    logic [1:0] dis_prev = '0, samp_prev = '0;
    int exp_d = 0, exp_s = 0;
    int dly = 0, acks = 0, seq = 0;
    logic last_chan = 1'b0;
    logic [15:0] last_data = '0;
    logic both_exp = 1'b0;

    shc_top uut (.*);

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot_of(input logic ch);
        return ch ? 23 : 22;
    endfunction

    // Converter model and output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (dis_o[i]) dis_run[i]++;
                if (dis_prev[i] && !dis_o[i]) begin
                    check(dis_run[i] == exp_d + 1, "R4 discharge length", dis_run[i], exp_d + 1);
                    check(samp_o[i] == 1'b1, "R4 sample follows discharge", samp_o[i], 1);
                end
                if (!dis_o[i]) dis_run[i] = 0;
                if (samp_o[i]) samp_run[i]++;
                if (samp_prev[i] && !samp_o[i])
                    check(samp_run[i] == exp_s + 1, "R4 sample length", samp_run[i], exp_s + 1);
                if (!samp_o[i]) samp_run[i] = 0;
            end
            dis_prev  = dis_o;
            samp_prev = samp_o;
            if (buf_we) begin
                check(int'(buf_addr) == slot_of(last_chan), "R7 slot", buf_addr, slot_of(last_chan));
                check(buf_wdata == last_data, "R7 data", buf_wdata, last_data);
                check(irq_o[last_chan] == 1'b1, "R8 flag with write", irq_o[last_chan], 1);
                wr_cnt[last_chan]++;
            end
            if (conv_ack) begin
                conv_ack = 1'b0;
                dly = int'($urandom % 4);
            end else if (conv_req) begin
                if (dly == 0) begin
                    if (acks == 0 && both_exp)
                        check(conv_chan == 1'b0, "R6 channel 0 first", conv_chan, 0);
                    seq++;
                    last_chan = conv_chan;
                    last_data = {conv_chan, 3'b101, 12'(seq * 37)};
                    conv_data = last_data;
                    conv_ack  = 1'b1;
                    acks++;
                end else begin
                    dly--;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (dis_o != 0 || samp_o != 0 || conv_req || buf_we || conv_ack) q = 0;
            else q++;
        end
    endtask

    task automatic clear_counts();
        wr_cnt[0] = 0; wr_cnt[1] = 0; acks = 0;
    endtask

    initial begin
        logic [15:0] rv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dis_o == 0 && samp_o == 0 && !conv_req && !buf_we && irq_o == 0, "R1 outputs", 1, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), rv);
            check(rv == 0, "R1 register", rv, 0);
        end

        // Randomized captures: R2 R5 R6 R7 R8
        for (int it = 0; it < 60; it++) begin
            logic dual;
            logic [1:0] en, tp, expw;
            dual = 1'($urandom % 2);
            en   = 2'($urandom % 4);
            tp   = 2'($urandom % 4);
            exp_d = int'($urandom % 6);
            exp_s = int'($urandom % 6);
            wr(2'd0, {13'd0, dual, en});
            wr(2'd1, 16'((exp_s << 8) | exp_d));
            expw = (dual ? {2{tp[0]}} : tp) & en;
            clear_counts();
            both_exp = (expw == 2'b11);
            @(negedge clk);
            trig_in = tp;
            repeat (4) @(negedge clk);
            trig_in = 2'b00;
            repeat (3) @(negedge clk);
            wait_quiet();
            check(wr_cnt[0] == int'(expw[0]), "R2 R5 channel 0 writes", wr_cnt[0], expw[0]);
            check(wr_cnt[1] == int'(expw[1]), "R2 R5 channel 1 writes", wr_cnt[1], expw[1]);
            check(irq_o == expw, "R8 irq flags", irq_o, expw);
            rd(2'd2, rv);
            check(rv == {14'd0, expw}, "R8 flag register", rv, expw);
            wr(2'd2, 16'h0003);
            @(negedge clk);
            check(irq_o == 2'b00, "R9 write-one clear", irq_o, 0);
            both_exp = 1'b0;
        end

        // R3 start latency and level held high
        exp_d = 1; exp_s = 1;
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0101);
        clear_counts();
        @(negedge clk);
        trig_in = 2'b01;
        @(negedge clk);
        @(negedge clk);
        check(dis_o[0] == 1'b0, "R3 not yet started", dis_o[0], 0);
        @(negedge clk);
        check(dis_o[0] == 1'b1, "R3 discharge on third edge", dis_o[0], 1);
        repeat (40) @(negedge clk);
        wait_quiet();
        trig_in = 2'b00;
        check(wr_cnt[0] == 1, "R3 held level one capture", wr_cnt[0], 1);

        // R10 retrigger during a long discharge
        exp_d = 20; exp_s = 2;
        wr(2'd1, 16'h0214);
        clear_counts();
        @(negedge clk);
        trig_in = 2'b01;
        repeat (3) @(negedge clk);
        trig_in = 2'b00;
        repeat (3) @(negedge clk);
        trig_in = 2'b01;
        repeat (3) @(negedge clk);
        trig_in = 2'b00;
        wait_quiet();
        check(wr_cnt[0] == 1, "R10 busy retrigger ignored", wr_cnt[0], 1);

        // R9 flag survives a zero write and a new capture
        wr(2'd2, 16'h0000);
        @(negedge clk);
        check(irq_o[0] == 1'b1, "R9 zero write keeps flag", irq_o[0], 1);
        exp_d = 2; exp_s = 2;
        wr(2'd1, 16'h0202);
        trig_in = 2'b01;
        repeat (5) @(negedge clk);
        check(irq_o[0] == 1'b1, "R9 flag kept during new capture", irq_o[0], 1);
        trig_in = 2'b00;
        wait_quiet();
        wr(2'd2, 16'h0002);
        @(negedge clk);
        check(irq_o[0] == 1'b1, "R9 other bit leaves flag", irq_o[0], 1);
        wr(2'd2, 16'h0001);
        @(negedge clk);
        check(irq_o[0] == 1'b0, "R9 flag cleared", irq_o[0], 0);

        // R2 disabled channel 1 in separate mode
        clear_counts();
        trig_in = 2'b10;
        repeat (4) @(negedge clk);
        check(dis_o[1] == 1'b0, "R2 disabled no discharge", dis_o[1], 0);
        trig_in = 2'b00;
        wait_quiet();
        check(wr_cnt[1] == 0 && irq_o[1] == 1'b0, "R2 disabled no write", wr_cnt[1], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule